// File: doc/BRIEF.md
# Request/Grant/Acknowledge Bus Arbiter

This block decides who drives a shared asynchronous bus. The processor owns the bus by default. Four other masters can ask for it: a memory refresh unit, two DMA engines and one external master. A master asks by raising its request and then waits for its grant. It waits until the bus is quiet, meaning the address strobe and the acknowledge line are both low. Then it raises acknowledge and runs its own cycles. It drops its request, which makes the grant fall, and it keeps acknowledge high until its last cycle is done. The internal masters use the same sequence over on-chip request and acknowledge lines. The external master uses the pins.

The external request, the acknowledge pin, the address strobe and the upstream grant arrive asynchronously. Each of them passes through a two-flop synchronizer before the state machine sees it. An owner code shows which master holds the bus at any time.

A mode input turns the block around. In that mode it stops granting and instead raises a request towards an outside arbiter on behalf of its internal masters. Once it holds the bus it drives acknowledge itself. An outside processor can then reach the on-chip resources without any handshake.

Top module: `bus_arb3w`

## Requirements
- R1: While reset is asserted and after it is released, all grants, `up_req_o` and `up_ack_o` are low and `owner_o` is 0 (processor).
- R2: The external request, acknowledge pin, address strobe and upstream grant each pass through two flops. `ext_grant_o` rises after the third rising edge that samples the external request. An internal grant rises after the first edge that samples its request line.
- R3: When requests are pending together, the grant follows a fixed priority: `int_req_i[0]` (refresh), then `int_req_i[1]` (DMA A), then `int_req_i[2]` (DMA B), then the external master. At most one grant is high.
- R4: Once a grant is offered, the winner stays fixed. A higher-priority request that arrives later does not take the grant away from it.
- R5: The owner switches from the processor to the granted master only on an edge where the synchronized combined acknowledge is high and both acknowledge and address strobe were low on the previous edge. An acknowledge that stays high from an earlier owner never hands over the bus. Owner codes: 0 processor, 1 refresh, 2 DMA A, 3 DMA B, 4 external.
- R6: When the owning master drops its request while it still holds acknowledge, its grant falls on the next edge that samples the dropped request. The owner code stays until acknowledge is seen low, and then returns to 0.
- R7: If the winner drops its request before it takes over, the grant is withdrawn and the owner stays 0. If the drop and the acknowledge rise are seen on the same edge, the drop wins.
- R8: An internal acknowledge line (`int_ack_i`) is used unsynchronized and has the same effect on handover and release as the acknowledge pin.
- R9: With `rev_mode_i` high, no external grant is ever given. An internal request raises `up_req_o`. Once `up_grant_i` is seen high and the bus is then seen quiet, the block raises `up_ack_o` and drops `up_req_o`. In the same step it raises the winner's internal grant and shows the winner's owner code. When that request drops, all of these clear.
- R10: `rev_mode_i` is taken only while the arbiter is idle. A change of the input while a master holds or is offered the bus takes effect only after the bus returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rev_mode_i | input | 1 | 1 = block requests the bus upstream instead of granting |
| ext_req_i | input | 1 | External master bus request (asynchronous) |
| ack_pin_i | input | 1 | Bus grant-acknowledge pin (asynchronous) |
| as_pin_i | input | 1 | Address strobe (asynchronous) |
| up_grant_i | input | 1 | Grant from the upstream arbiter in reversed mode (asynchronous) |
| int_req_i | input | N_INT | Internal request lines: bit 0 refresh, bit 1 DMA A, bit 2 DMA B |
| int_ack_i | input | N_INT | Internal acknowledge lines |
| ext_grant_o | output | 1 | Grant to the external master |
| int_grant_o | output | N_INT | Grants to the internal masters |
| up_req_o | output | 1 | Request to the upstream arbiter in reversed mode |
| up_ack_o | output | 1 | Acknowledge driven by the block in reversed mode |
| owner_o | output | 3 | Current bus owner code |

## Verification
While an offer is open, the winner's request can drop on the same edge that its acknowledge rise is sampled. The arbiter must then choose between withdrawing the grant and handing over the bus. The bench drops an internal request and raises its acknowledge at the same falling edge, and expects the grant to vanish while the owner stays at the processor. Random toggling of requests and acknowledges repeats this overlap, and a step-by-step model of the requirements judges every cycle.

// File: rtl/arb3w_pkg.sv
package arb3w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OFFER = 3'd1,
    ST_READY = 3'd2,
    ST_HELD  = 3'd3,
    ST_DRAIN = 3'd4
  } arb_st_e;

  // bit slots of the synchronized pin vector
  localparam int SYNC_W  = 4;
  localparam int SB_EREQ = 3;
  localparam int SB_ACK  = 2;
  localparam int SB_AS   = 1;
  localparam int SB_UGNT = 0;

endpackage

// File: rtl/arb3w_rst_sync.sv
module arb3w_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/arb3w_sync.sv
module arb3w_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/arb3w_pick.sv
module arb3w_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign pick[i]   = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/arb3w_fsm.sv
module arb3w_fsm
  import arb3w_pkg::*;
#(
  parameter int N_INT = 3,
  parameter int OWN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic [N_INT:0]   req_vec,
  input  logic [N_INT:0]   pick,
  input  logic             as_s,
  input  logic             ack_s,
  input  logic             ugnt_s,
  output logic [N_INT:0]   gnt_vec,
  output logic             up_req,
  output logic             up_ack,
  output logic [OWN_W-1:0] owner
);
  localparam int NM = N_INT + 1;

  arb_st_e       st_q, st_n;
  logic [NM-1:0] win_q;
  logic          mode_q;
  logic          ack_q, as_q;
  logic          ld_win;
  logic          win_req;
  logic          ack_rise;
  logic          gnt_on;
  logic [OWN_W-1:0] own_code;

  assign win_req  = |(req_vec & win_q);
  assign ack_rise = ack_s & ~ack_q & ~as_q;
  assign ld_win   = (st_q == ST_IDLE);

  // next-state logic
  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (|pick) st_n = ST_OFFER;
      end
      ST_OFFER: begin
        if (!win_req)    st_n = ST_IDLE;
        else if (mode_q) begin
          if (ugnt_s)    st_n = ST_READY;
        end
        else if (ack_rise) st_n = ST_HELD;
      end
      ST_READY: begin
        if (!win_req || !ugnt_s)  st_n = ST_IDLE;
        else if (!as_s && !ack_s) st_n = ST_HELD;
      end
      ST_HELD: begin
        if (mode_q) begin
          if (!win_req) st_n = ST_IDLE;
        end
        else if (!ack_s)   st_n = ST_IDLE;
        else if (!win_req) st_n = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!ack_s) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      win_q  <= '0;
      mode_q <= 1'b0;
      ack_q  <= 1'b0;
      as_q   <= 1'b0;
    end else begin
      st_q  <= st_n;
      ack_q <= ack_s;
      as_q  <= as_s;
      if (ld_win) begin
        win_q  <= pick;
        mode_q <= mode_i;
      end
    end
  end

  // outputs decoded from registers only
  assign gnt_on  = mode_q ? (st_q == ST_HELD)
                          : ((st_q == ST_OFFER) || (st_q == ST_HELD));
  assign gnt_vec = gnt_on ? win_q : '0;
  assign up_req  = mode_q && ((st_q == ST_OFFER) || (st_q == ST_READY));
  assign up_ack  = mode_q && (st_q == ST_HELD);

  always_comb begin
    own_code = '0;
    for (int i = 0; i < NM; i++) begin
      if (win_q[i]) own_code = OWN_W'(i + 1);
    end
  end

  assign owner = ((st_q == ST_HELD) || (st_q == ST_DRAIN)) ? own_code : '0;

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_q)); // R3
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec)); // R3
  AST_TAKE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && owner != '0 && $past(owner) == '0) |-> $past(ack_s)); // R5
  AST_RELEASE_DROPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && st_q == ST_HELD && !win_req && ack_s) |=> (gnt_vec == '0)); // R6
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFFER && !win_req) |=> (gnt_vec == '0 && owner == '0 && !up_req)); // R7
  AST_REV_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !gnt_vec[N_INT]); // R9
  AST_UP_ONLY_REV: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req || up_ack) |-> (mode_q && !(up_req && up_ack))); // R9
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(mode_q)); // R10

endmodule

// File: rtl/bus_arb3w.sv
module bus_arb3w
  import arb3w_pkg::*;
#(
  parameter  int N_INT       = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int OWN_W       = $clog2(N_INT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rev_mode_i,
  input  logic             ext_req_i,
  input  logic             ack_pin_i,
  input  logic             as_pin_i,
  input  logic             up_grant_i,
  input  logic [N_INT-1:0] int_req_i,
  input  logic [N_INT-1:0] int_ack_i,
  output logic             ext_grant_o,
  output logic [N_INT-1:0] int_grant_o,
  output logic             up_req_o,
  output logic             up_ack_o,
  output logic [OWN_W-1:0] owner_o
);
  logic              rst_q_n;
  logic [SYNC_W-1:0] pin_raw, pin_s;
  logic [N_INT:0]    req_vec, cand, pick, gnt_vec;
  logic              ack_all;

  arb3w_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign pin_raw = {ext_req_i, ack_pin_i, as_pin_i, up_grant_i};

  arb3w_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     (pin_raw),
    .q     (pin_s)
  );

  assign req_vec = {pin_s[SB_EREQ], int_req_i};
  assign cand    = req_vec & {~rev_mode_i, {N_INT{1'b1}}};
  assign ack_all = pin_s[SB_ACK] | (|int_ack_i);

  arb3w_pick #(.N(N_INT + 1)) u_pick (
    .req  (cand),
    .pick (pick)
  );

  arb3w_fsm #(.N_INT(N_INT), .OWN_W(OWN_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .mode_i  (rev_mode_i),
    .req_vec (req_vec),
    .pick    (pick),
    .as_s    (pin_s[SB_AS]),
    .ack_s   (ack_all),
    .ugnt_s  (pin_s[SB_UGNT]),
    .gnt_vec (gnt_vec),
    .up_req  (up_req_o),
    .up_ack  (up_ack_o),
    .owner   (owner_o)
  );

  assign ext_grant_o = gnt_vec[N_INT];
  assign int_grant_o = gnt_vec[N_INT-1:0];

endmodule

// File: tb/test_bus_arb3w.sv
module test_bus_arb3w;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rev_mode = 1'b0;
  logic       ext_req = 1'b0, ack_pin = 1'b0, as_pin = 1'b0, up_grant = 1'b0;
  logic [2:0] int_req = 3'b000, int_ack = 3'b000;
  logic       ext_grant, up_req, up_ack;
  logic [2:0] int_grant, owner;

  int total = 0;
  int fails = 0;
  logic cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  bus_arb3w i_bus_arb3w (
    .clk         (clk),
    .rst_n       (rst_n),
    .rev_mode_i  (rev_mode),
    .ext_req_i   (ext_req),
    .ack_pin_i   (ack_pin),
    .as_pin_i    (as_pin),
    .up_grant_i  (up_grant),
    .int_req_i   (int_req),
    .int_ack_i   (int_ack),
    .ext_grant_o (ext_grant),
    .int_grant_o (int_grant),
    .up_req_o    (up_req),
    .up_ack_o    (up_ack),
    .owner_o     (owner)
  );

  task automatic check(string rq, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] first_set(logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return 4'(1 << i);
    return 4'b0;
  endfunction

  function automatic int code_of(logic [3:0] w);
    for (int i = 0; i < 4; i++) if (w[i]) return i + 1;
    return 0;
  endfunction

  // reference model built from the requirements
  logic [3:0] p1, p2;
  int         m_st;
  logic [3:0] m_win;
  logic       m_mode, m_ackq, m_asq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= '0; p2 <= '0; m_st <= 0; m_win <= '0;
      m_mode <= 1'b0; m_ackq <= 1'b0; m_asq <= 1'b0;
    end else begin
      logic ackv, asv, ugv, wr;
      logic [3:0] rv, pk;
      int ns;
      ackv = p2[2] | (|int_ack);
      asv  = p2[1];
      ugv  = p2[0];
      rv   = {p2[3], int_req};
      wr   = |(rv & m_win);
      pk   = first_set(rv & {~rev_mode, 3'b111});
      ns   = m_st;
      case (m_st)
        0: if (pk != 0) ns = 1;
        1: if (!wr) ns = 0;
           else if (m_mode) begin if (ugv) ns = 2; end
           else if (ackv && !m_ackq && !m_asq) ns = 3;
        2: if (!wr || !ugv) ns = 0; else if (!asv && !ackv) ns = 3;
        3: if (m_mode) begin if (!wr) ns = 0; end
           else if (!ackv) ns = 0; else if (!wr) ns = 4;
        4: if (!ackv) ns = 0;
        default: ns = 0;
      endcase
      if (m_st == 0) begin
        m_win  <= pk;
        m_mode <= rev_mode;
      end
      m_st   <= ns;
      m_ackq <= ackv;
      m_asq  <= asv;
      p1     <= {ext_req, ack_pin, as_pin, up_grant};
      p2     <= p1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      logic on;
      logic [3:0] eg;
      on = m_mode ? (m_st == 3) : (m_st == 1 || m_st == 3);
      eg = on ? m_win : 4'b0;
      check("R3", "grants", int'({ext_grant, int_grant}), int'(eg));
      check("R5", "owner", int'(owner), (m_st == 3 || m_st == 4) ? code_of(m_win) : 0);
      check("R9", "up_req/up_ack", int'({up_req, up_ack}),
            int'({m_mode && (m_st == 1 || m_st == 2), m_mode && m_st == 3}));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    tick(3);
    check("R1", "owner in reset", int'(owner), 0);
    check("R1", "grants in reset", int'({ext_grant, int_grant, up_req, up_ack}), 0);
    rst_n = 1'b1;
    tick(4);
    check("R1", "grants after reset", int'({ext_grant, int_grant, up_req, up_ack}), 0);
    cmp_en = 1'b1;

    // internal handshake
    int_req = 3'b001; tick(1);
    check("R2", "refresh grant", int'(int_grant), 1);
    check("R5", "owner before ack", int'(owner), 0);
    int_ack = 3'b001; tick(1);
    check("R8", "owner after internal ack", int'(owner), 1);
    int_req = 3'b000; tick(1);
    check("R6", "grant after req drop", int'(int_grant), 0);
    check("R6", "owner kept while ack", int'(owner), 1);
    int_ack = 3'b000; tick(1);
    check("R6", "owner after ack low", int'(owner), 0);
    tick(2);

    // external handshake with a stale acknowledge
    ack_pin = 1'b1; tick(3);
    ext_req = 1'b1; tick(2);
    check("R2", "ext grant still synchronizing", int'(ext_grant), 0);
    tick(1);
    check("R2", "ext grant third edge", int'(ext_grant), 1);
    tick(4);
    check("R5", "stale ack ignored", int'(owner), 0);
    ack_pin = 1'b0; tick(4);
    ack_pin = 1'b1; tick(2);
    check("R5", "ack not yet through", int'(owner), 0);
    tick(1);
    check("R5", "external owns", int'(owner), 4);
    ext_req = 1'b0; tick(2);
    check("R6", "ext grant before drop seen", int'(ext_grant), 1);
    tick(1);
    check("R6", "ext grant after drop", int'(ext_grant), 0);
    check("R6", "ext owner kept", int'(owner), 4);
    ack_pin = 1'b0; tick(3);
    check("R6", "owner back to processor", int'(owner), 0);
    tick(2);

    // priority and latching
    ext_req = 1'b1; int_req = 3'b110; tick(1);
    check("R3", "DMA A over DMA B", int'({ext_grant, int_grant}), 2);
    int_req = 3'b111; tick(2);
    check("R4", "winner kept", int'({ext_grant, int_grant}), 2);
    int_req = 3'b101; tick(1);
    check("R7", "withdrawn", int'({ext_grant, int_grant}), 0);
    tick(1);
    check("R3", "refresh first", int'({ext_grant, int_grant}), 1);
    int_req = 3'b100; tick(2);
    check("R3", "DMA B over external", int'({ext_grant, int_grant}), 4);
    int_req = 3'b000; tick(2);
    check("R3", "external last", int'({ext_grant, int_grant}), 8);
    ext_req = 1'b0; tick(4);
    check("R7", "ext withdrawn", int'(ext_grant), 0);
    tick(2);

    // drop and acknowledge on the same edge
    int_req = 3'b010; tick(1);
    int_req = 3'b000; int_ack = 3'b010; tick(1);
    check("R7", "drop beats ack grant", int'(int_grant), 0);
    check("R7", "drop beats ack owner", int'(owner), 0);
    int_ack = 3'b000; tick(2);

    // reversed mode
    rev_mode = 1'b1; ext_req = 1'b1; int_req = 3'b001; tick(1);
    check("R9", "up_req raised", int'(up_req), 1);
    check("R9", "no grant yet", int'({ext_grant, int_grant}), 0);
    up_grant = 1'b1; tick(3);
    check("R9", "waiting for quiet bus", int'({up_req, up_ack}), 2);
    tick(1);
    check("R9", "up_ack and grant", int'({up_req, up_ack}), 1);
    check("R9", "internal grant", int'({ext_grant, int_grant}), 1);
    check("R9", "owner refresh", int'(owner), 1);
    int_req = 3'b000; tick(1);
    check("R9", "released", int'({up_req, up_ack, int_grant}), 0);
    up_grant = 1'b0; tick(3);
    check("R9", "ext ignored in reversed mode", int'(ext_grant), 0);
    ext_req = 1'b0; rev_mode = 1'b0; tick(4);

    // mode change while owned
    int_req = 3'b010; tick(1);
    int_ack = 3'b010; tick(1);
    rev_mode = 1'b1; tick(2);
    check("R10", "mode frozen owner", int'(owner), 2);
    check("R10", "mode frozen up_req", int'(up_req), 0);
    int_req = 3'b000; int_ack = 3'b000; tick(1);
    int_req = 3'b100; tick(1);
    check("R10", "new mode after idle", int'(up_req), 1);
    int_req = 3'b000; tick(1);
    rev_mode = 1'b0; tick(3);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(7) == 0)   ext_req  = ~ext_req;
      if ($urandom_range(4) == 0)   ack_pin  = ~ack_pin;
      if ($urandom_range(3) == 0)   as_pin   = ~as_pin;
      if ($urandom_range(5) == 0)   up_grant = ~up_grant;
      if ($urandom_range(199) == 0) rev_mode = ~rev_mode;
      for (int b = 0; b < 3; b++) begin
        if ($urandom_range(5) == 0) int_req[b] = ~int_req[b];
        if ($urandom_range(4) == 0) int_ack[b] = ~int_ack[b];
      end
      tick(1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule